// File: doc/BRIEF.md
# Ternary Cube Lookup Memory

This block is a small ternary content-addressable memory whose entries are Boolean cubes. Each cube position holds 0, 1 or don't-care. Software-free control logic next to it writes cubes into numbered slots, retires slots, and issues queries. A query is one cube plus a relation. Every valid slot is tested against that relation in the same cycle.

Four relations are offered. The first is an ordinary ternary match, where a don't-care on either side always agrees. The second is a cover search, which finds the stored cubes that include the query cube. The third is a containment search, which finds the stored cubes that lie inside the query cube. The last is an identity search, which finds a stored cube equal to the query at every position, don't-cares included. The identity result is formed as the AND of the cover and containment results.

One clock after a query, the block presents a per-slot hit vector, an any-hit flag and the index of the lowest hitting slot. A cube-merging minimizer uses these relations to locate redundant or absorbable terms.

Top module: `tcam_cube_lookup`

## Requirements
- R1: After reset no slot is valid, and `hit_vec`, `hit_any`, `hit_idx` and `res_vld` are all zero.
- R2: A cube position is carried as a pair of bits, one in each of two vectors (`*_d0` and `*_d1`). d0=1,d1=0 means 1. d0=0,d1=1 means 0. d0=0,d1=0 means don't-care. Stored cubes and query cubes use this same encoding. The pair 1,1 is never written.
- R3: With `lk_mode`=2'b00 (plain match), a valid slot hits when no position holds opposite specified values in the slot and in the query. A don't-care on either side agrees.
- R4: With `lk_mode`=2'b01 (cover), a valid slot hits when every position the slot specifies is specified with the same value in the query.
- R5: With `lk_mode`=2'b10 (contain), a valid slot hits when every position the query specifies is specified with the same value in the slot.
- R6: With `lk_mode`=2'b11 (identity), a valid slot hits exactly when it would hit in both cover and contain mode. It therefore hits only on a slot equal to the query at every position, don't-cares included.
- R7: A slot that was never written, or that was invalidated, never hits. Invalidating a slot clears only its valid state.
- R8: The result of a query appears on the outputs in the clock after `lk_en` was sampled high, together with a one-cycle `res_vld`. Without a query, the result outputs keep their values.
- R9: `hit_any` is high exactly when `hit_vec` is nonzero. `hit_idx` is the lowest set position of `hit_vec`, or 0 when there is no hit.
- R10: A write in the same cycle as a query is not seen by that query. It is seen by queries from the next cycle on.
- R11: A write and an invalidate to the same slot in the same cycle leave that slot invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a cube into slot `wr_addr` and mark it valid |
| wr_addr | input | IDX_W | Slot written |
| wr_d0 | input | WIDTH | Cube to write, "is one" half of each pair |
| wr_d1 | input | WIDTH | Cube to write, "is zero" half of each pair |
| inv_en | input | 1 | Invalidate slot `inv_addr` |
| inv_addr | input | IDX_W | Slot invalidated |
| lk_en | input | 1 | Start a query this cycle |
| lk_mode | input | 2 | Relation: 00 match, 01 cover, 10 contain, 11 identity |
| q_d0 | input | WIDTH | Query cube, "is one" half |
| q_d1 | input | WIDTH | Query cube, "is zero" half |
| hit_vec | output | DEPTH | Per-slot hit of the last query |
| hit_any | output | 1 | At least one slot hit |
| hit_idx | output | IDX_W | Lowest hitting slot |
| res_vld | output | 1 | Result updated this cycle |

## Verification
The bench builds the block with WIDTH=11 and DEPTH=8. Eleven positions are enough to hold a fully specified cube that mixes don't-cares between specified bits. The other slots specify only the low four positions. In identity searches those slots stay apart from the full-width cube, while in match mode they still agree with it wherever their don't-cares sit. Eight slots let one table of five query cubes land in every relation on hit sets of one, several and zero slots. This also leaves one slot to invalidate and one to hold the wide cube.

// File: rtl/tcam_cube_pkg.sv
package tcam_cube_pkg;

    typedef enum logic [1:0] {
        LK_MATCH   = 2'b00,
        LK_COVER   = 2'b01,
        LK_CONTAIN = 2'b10,
        LK_EXACT   = 2'b11
    } lk_mode_e;

endpackage

// File: rtl/tcam_sl_drive.sv
module tcam_sl_drive
    import tcam_cube_pkg::*;
#(
    parameter int WIDTH = 11
) (
    input  logic [WIDTH-1:0] q_d0,
    input  logic [WIDTH-1:0] q_d1,
    input  lk_mode_e         mode,
    output logic [WIDTH-1:0] sl0,
    output logic [WIDTH-1:0] sl1
);

    // Cover-type searches turn a query don't-care into a double-driven
    // line pair, so any specified stored bit breaks the match there.
    logic dc_fill;
    assign dc_fill = (mode == LK_COVER) || (mode == LK_EXACT);

    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic is_dc;
        assign is_dc  = ~q_d0[b] & ~q_d1[b];
        assign sl1[b] = q_d0[b] | (is_dc & dc_fill);
        assign sl0[b] = q_d1[b] | (is_dc & dc_fill);
    end

endmodule

// File: rtl/tcam_row.sv
module tcam_row
    import tcam_cube_pkg::*;
#(
    parameter int WIDTH = 11
) (
    input  logic [WIDTH-1:0] ent_d0,
    input  logic [WIDTH-1:0] ent_d1,
    input  logic             ent_vld,
    input  logic [WIDTH-1:0] sl0,
    input  logic [WIDTH-1:0] sl1,
    input  logic [WIDTH-1:0] q_d0,
    input  logic [WIDTH-1:0] q_d1,
    input  lk_mode_e         mode,
    output logic             hit
);

    logic [WIDTH-1:0] cell_miss;
    logic [WIDTH-1:0] cont_miss;

    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        logic q_spec;
        logic same;
        // Match line is pulled low when a driven line meets its active stored line.
        assign cell_miss[b] = (sl0[b] & ent_d0[b]) | (sl1[b] & ent_d1[b]);
        // Containment compare: a specified query bit needs an identical stored bit.
        assign q_spec       = q_d0[b] | q_d1[b];
        assign same         = (q_d0[b] == ent_d0[b]) && (q_d1[b] == ent_d1[b]);
        assign cont_miss[b] = q_spec & ~same;
    end

    logic line_ok;
    logic cont_ok;
    logic rel_ok;

    assign line_ok = ~|cell_miss;
    assign cont_ok = ~|cont_miss;

    always_comb begin
        unique case (mode)
            LK_MATCH:   rel_ok = line_ok;
            LK_COVER:   rel_ok = line_ok;
            LK_CONTAIN: rel_ok = cont_ok;
            LK_EXACT:   rel_ok = line_ok & cont_ok;
            default:    rel_ok = 1'b0;
        endcase
    end

    assign hit = ent_vld & rel_ok;

endmodule

// File: rtl/tcam_lowest.sv
module tcam_lowest #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    vec,
    output logic            any,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_cube_lookup.sv
module tcam_cube_lookup
    import tcam_cube_pkg::*;
#(
    parameter int WIDTH = 11,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_d0,
    input  logic [WIDTH-1:0] wr_d1,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_addr,
    input  logic             lk_en,
    input  logic [1:0]       lk_mode,
    input  logic [WIDTH-1:0] q_d0,
    input  logic [WIDTH-1:0] q_d1,
    output logic [DEPTH-1:0] hit_vec,
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx,
    output logic             res_vld
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] d0;
        logic [DEPTH-1:0][WIDTH-1:0] d1;
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0]            hits;
        logic                        any;
        logic [IDX_W-1:0]            idx;
        logic                        rvld;
    } state_t;

    state_t st_d, st_q;

    lk_mode_e         mode;
    logic [WIDTH-1:0] sl0, sl1;
    logic [DEPTH-1:0] row_hit;
    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;

    assign mode = lk_mode_e'(lk_mode);

    tcam_sl_drive #(.WIDTH(WIDTH)) u_sl (
        .q_d0 (q_d0),
        .q_d1 (q_d1),
        .mode (mode),
        .sl0  (sl0),
        .sl1  (sl1)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_row
        tcam_row #(.WIDTH(WIDTH)) u_row (
            .ent_d0  (st_q.d0[e]),
            .ent_d1  (st_q.d1[e]),
            .ent_vld (st_q.valid[e]),
            .sl0     (sl0),
            .sl1     (sl1),
            .q_d0    (q_d0),
            .q_d1    (q_d1),
            .mode    (mode),
            .hit     (row_hit[e])
        );
    end

    tcam_lowest #(.N(DEPTH), .IDXW(IDX_W)) u_enc (
        .vec (row_hit),
        .any (enc_any),
        .idx (enc_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = lk_en;
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            st_d.d0[wr_addr]    = wr_d0;
            st_d.d1[wr_addr]    = wr_d1;
            st_d.valid[wr_addr] = 1'b1;
        end
        if (inv_en && (int'(inv_addr) < DEPTH)) begin
            st_d.valid[inv_addr] = 1'b0;
        end
        if (lk_en) begin
            st_d.hits = row_hit;
            st_d.any  = enc_any;
            st_d.idx  = enc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_vec = st_q.hits;
    assign hit_any = st_q.any;
    assign hit_idx = st_q.idx;
    assign res_vld = st_q.rvld;

    logic [DEPTH-1:0] below_idx;
    assign below_idx = (DEPTH'(1) << hit_idx) - DEPTH'(1);

    AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_d0 & wr_d1) == '0)); // R2
    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> res_vld); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> $stable(hit_vec)); // R8
    AST_HIT_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> ((hit_vec & ~$past(st_q.valid)) == '0)); // R7
    AST_IDX_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> hit_vec[hit_idx]); // R9
    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> ((hit_vec & below_idx) == '0)); // R9

endmodule

// File: tb/tb_tcam_cube_lookup.sv
`timescale 1ns/1ps
module tb_tcam_cube_lookup;

    localparam int W  = 11;
    localparam int D  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_d0 = '0, wr_d1 = '0;
    logic          inv_en = 1'b0;
    logic [IW-1:0] inv_addr = '0;
    logic          lk_en = 1'b0;
    logic [1:0]    lk_mode = 2'b00;
    logic [W-1:0]  q_d0 = '0, q_d1 = '0;
    logic [D-1:0]  hit_vec;
    logic          hit_any;
    logic [IW-1:0] hit_idx;
    logic          res_vld;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tcam_cube_lookup #(.WIDTH(W), .DEPTH(D)) dut (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_d0, .wr_d1, .inv_en, .inv_addr,
        .lk_en, .lk_mode, .q_d0, .q_d1, .hit_vec, .hit_any, .hit_idx, .res_vld
    );

    typedef struct packed {
        logic [1:0]   mode;
        logic [W-1:0] care;
        logic [W-1:0] val;
        logic [D-1:0] vec;
    } vec_t;

    // Slots 0..5 hold low-nibble cubes 1011, 10xx, xxxx, 0110, 101x, 1x11; slot 6 invalidated.
    localparam vec_t TABLE [20] = '{
        '{2'b00, 11'h00F, 11'h00B, 8'h37}, '{2'b01, 11'h00F, 11'h00B, 8'h37},
        '{2'b10, 11'h00F, 11'h00B, 8'h01}, '{2'b11, 11'h00F, 11'h00B, 8'h01},
        '{2'b00, 11'h00C, 11'h008, 8'h37}, '{2'b01, 11'h00C, 11'h008, 8'h06},
        '{2'b10, 11'h00C, 11'h008, 8'h13}, '{2'b11, 11'h00C, 11'h008, 8'h02},
        '{2'b00, 11'h000, 11'h000, 8'h3F}, '{2'b01, 11'h000, 11'h000, 8'h04},
        '{2'b10, 11'h000, 11'h000, 8'h3F}, '{2'b11, 11'h000, 11'h000, 8'h04},
        '{2'b00, 11'h00F, 11'h007, 8'h04}, '{2'b01, 11'h00F, 11'h007, 8'h04},
        '{2'b10, 11'h00F, 11'h007, 8'h00}, '{2'b11, 11'h00F, 11'h007, 8'h00},
        '{2'b00, 11'h00A, 11'h00A, 8'h37}, '{2'b01, 11'h00A, 11'h00A, 8'h04},
        '{2'b10, 11'h00A, 11'h00A, 8'h31}, '{2'b11, 11'h00A, 11'h00A, 8'h00}
    };

    localparam logic [W-1:0] WIDE_CARE = 11'b11011100011;
    localparam logic [W-1:0] WIDE_VAL  = 11'b01000100001;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_result(input string req, input logic [D-1:0] exp_vec);
        logic [IW-1:0] exp_idx = '0;
        for (int i = D - 1; i >= 0; i--) if (exp_vec[i]) exp_idx = IW'(i);
        chk({req, " vec"}, 32'(hit_vec), 32'(exp_vec));
        chk({req, " any R9"}, 32'(hit_any), 32'(|exp_vec));
        chk({req, " idx R9"}, 32'(hit_idx), 32'(exp_idx));
        chk({req, " vld R8"}, 32'(res_vld), 32'd1);
    endtask

    task automatic set_wr(input int a, input logic [W-1:0] care, input logic [W-1:0] val);
        wr_en = 1'b1; wr_addr = IW'(a);
        wr_d0 = care & val; wr_d1 = care & ~val;
    endtask

    task automatic set_q(input logic [1:0] m, input logic [W-1:0] care, input logic [W-1:0] val);
        lk_en = 1'b1; lk_mode = m;
        q_d0 = care & val; q_d1 = care & ~val;
    endtask

    task automatic write(input int a, input logic [W-1:0] care, input logic [W-1:0] val);
        @(negedge clk); set_wr(a, care, val);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] m, input logic [W-1:0] care, input logic [W-1:0] val);
        @(negedge clk); set_q(m, care, val);
        @(negedge clk); lk_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset vec", 32'(hit_vec), 0);
        chk("R1 reset any", 32'(hit_any), 0);
        chk("R1 reset idx", 32'(hit_idx), 0);
        chk("R1 reset vld", 32'(res_vld), 0);
        rst_n = 1'b1;

        // R1 / R7: nothing written, all-don't-care match finds nothing
        lookup(2'b00, '0, '0);
        chk_result("R1 R7 empty", 8'h00);

        write(0, 11'h00F, 11'h00B);
        write(1, 11'h00C, 11'h008);
        write(2, 11'h000, 11'h000);
        write(3, 11'h00F, 11'h006);
        write(4, 11'h00E, 11'h00A);
        write(5, 11'h00B, 11'h00B);
        write(6, 11'h00F, 11'h00B);
        @(negedge clk); inv_en = 1'b1; inv_addr = 3'd6;
        @(negedge clk); inv_en = 1'b0;

        // Table walk: R3 match, R4 cover, R5 contain, R6 identity; slot 6 must not hit (R7)
        for (int k = 0; k < 20; k++) begin
            string tag;
            case (TABLE[k].mode)
                2'b00:   tag = "R3";
                2'b01:   tag = "R4";
                2'b10:   tag = "R5";
                default: tag = "R6";
            endcase
            lookup(TABLE[k].mode, TABLE[k].care, TABLE[k].val);
            chk_result($sformatf("%s row%0d R7", tag, k), TABLE[k].vec);
        end

        // R8: results hold while idle
        @(negedge clk);
        chk("R8 hold vec", 32'(hit_vec), 32'h00);
        chk("R8 idle vld", 32'(res_vld), 0);

        // R10: write of the wide cube in the same cycle as its identity query
        @(negedge clk); set_wr(7, WIDE_CARE, WIDE_VAL); set_q(2'b11, WIDE_CARE, WIDE_VAL);
        @(negedge clk); wr_en = 1'b0; lk_en = 1'b0;
        chk_result("R10 same cycle hidden", 8'h00);
        lookup(2'b11, WIDE_CARE, WIDE_VAL);
        chk_result("R10 R6 next cycle", 8'h80);
        lookup(2'b11, WIDE_CARE, WIDE_VAL & ~11'd1);
        chk_result("R6 one bit off", 8'h00);
        lookup(2'b11, WIDE_CARE & ~11'd1, WIDE_VAL & ~11'd1);
        chk_result("R6 extra dc", 8'h00);
        lookup(2'b01, WIDE_CARE & ~11'd1, WIDE_VAL & ~11'd1);
        chk_result("R4 wider query not covered", 8'h04);
        lookup(2'b10, WIDE_CARE & ~11'd1, WIDE_VAL & ~11'd1);
        chk_result("R5 wide inside query", 8'h80);

        // R11: write and invalidate of slot 6 together leave it invalid
        @(negedge clk); set_wr(6, 11'h00F, 11'h00B); inv_en = 1'b1; inv_addr = 3'd6;
        @(negedge clk); wr_en = 1'b0; inv_en = 1'b0;
        lookup(2'b00, 11'h00F, 11'h00B);
        chk_result("R11 R3 slot6 stays invalid", 8'h37);

        // R7: invalidating slot 0 removes only its hit
        @(negedge clk); inv_en = 1'b1; inv_addr = 3'd0;
        @(negedge clk); inv_en = 1'b0;
        lookup(2'b11, 11'h00F, 11'h00B);
        chk_result("R7 invalidated exact", 8'h00);
        lookup(2'b00, 11'h00F, 11'h00B);
        chk_result("R7 R9 lowest moves", 8'h36);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule